// File: doc/BRIEF.md
# Receive 5B-to-Nibble Code-Group Translator

This block sits on the receive side of a 100 Mb/s physical layer, after the descrambler and the serial-to-parallel stage. Each clock it takes one 5-bit code-group and produces one nibble on the media-independent receive interface, together with a data-valid flag and an error flag. Every mode has the same two-cycle latency, so the block can replace a plain register stage without changing the timing around it.

In the normal translating mode, data code-groups are decoded to nibbles. The start-of-stream pair is replaced by two preamble nibbles, and the end-of-stream pair is removed. The two bypass modes let a repeater controller work on raw code-groups. The code bypass mode sends the four low bits on the nibble bus and the fifth bit on the error flag. It leaves delimiters in place but still frames the packet with the data-valid flag. The full bypass mode passes every code-group unaltered, idles included.

The mode comes from two strap inputs latched during reset and two configuration bits. Either source can enable a bypass. Alignment bypass takes precedence over code bypass.

Top module: `rx_4b5b_xlat`

## Requirements
- R1: In translating mode (no bypass active), the sixteen data code-groups decode as follows: 11110→0, 01001→1, 10100→2, 10101→3, 01010→4, 01011→5, 01110→6, 01111→7, 10010→8, 10011→9, 10110→A, 10111→B, 11010→C, 11011→D, 11100→E, 11101→F. Each decoded nibble appears with `rx_dv`=1 and `rx_er`=0 while inside a frame.
- R2: In translating mode, a J code-group (11000) immediately followed by a K code-group (10001), seen outside a frame, is output as two nibbles of value 5 with `rx_dv`=1, starting the frame. A J that is not followed by K does not start a frame.
- R3: In translating mode, a T code-group (01101) immediately followed by an R code-group (00111) inside a frame ends it. Both are removed: `rx_dv`=0 and `rxd`=0 for those two positions.
- R4: In translating mode, a non-data code-group inside a frame (other than idle or the T/R pair) gives `rx_dv`=1, `rx_er`=1 and `rxd`=0. Outside a frame, every output stays 0 for any code-group.
- R5: In translating mode, an idle code-group (11111) inside a frame ends the frame, and `rx_dv`=0 from that position on.
- R6: In code bypass mode, `rxd` carries code-group bits [3:0] and `rx_er` carries bit 4. J, K, T and R pass through unmodified. An idle (11111) appears as `rxd`=0 with `rx_er`=0.
- R7: In code bypass mode, `rx_dv` takes, for every code-group position, the value that translating mode would give.
- R8: In alignment bypass mode, every code-group, idles included, appears as `rxd`=bits [3:0] and `rx_er`=bit 4, with `rx_dv`=0.
- R9: Code bypass is active when `strap_bypass_code` was high while `rst_n` was low, or when `cfg_bypass_code`=1. Alignment bypass is active in the same way from `strap_bypass_align` or `cfg_bypass_align`. Alignment bypass wins when both are active. Strap levels after reset release have no effect.
- R10: The outputs for a code-group appear two clock edges after the edge that samples it, in every mode. While in reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Code-group clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are latched while low |
| strap_bypass_code | input | 1 | Strap requesting code bypass, latched in reset |
| strap_bypass_align | input | 1 | Strap requesting alignment bypass, latched in reset |
| cfg_bypass_code | input | 1 | Configuration bit requesting code bypass |
| cfg_bypass_align | input | 1 | Configuration bit requesting alignment bypass |
| cg_in | input | 5 | Descrambled code-group, one per clock |
| rxd | output | 4 | Receive nibble |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error, or code-group bit 4 in bypass modes |

## Verification
Several cases only show up with particular code-group sequences inside a frame, and the stimulus has to build them on purpose. One is a J with no K behind it. Others are an invalid code-group, or an idle, arriving in the middle of a frame. A further case is code bypass with delimiters present, where `rx_dv` must still frame the packet although the delimiters themselves reach the nibble bus.

The bench builds whole frames that contain every data code-group and adds these broken sequences. It replays the same streams in each mode, with the mode set once through configuration bits and once through straps latched at reset. The straps are dropped right after release. A full 32-value sweep in alignment bypass covers every raw code-group.

// File: rtl/rx4b5b_pkg.sv
// Package: shared code-group constants and types for the receive translator.
// Assumes a 5-bit code-group alphabet and a 4-bit receive nibble.
package rx4b5b_pkg;

    localparam int CG_W  = 5;
    localparam int NIB_W = 4;

    localparam logic [CG_W-1:0]  CG_IDLE = 5'b11111;
    localparam logic [CG_W-1:0]  CG_J    = 5'b11000;
    localparam logic [CG_W-1:0]  CG_K    = 5'b10001;
    localparam logic [CG_W-1:0]  CG_T    = 5'b01101;
    localparam logic [CG_W-1:0]  CG_R    = 5'b00111;
    localparam logic [NIB_W-1:0] NIB_PRE = 4'h5;

    typedef enum logic [1:0] {
        MODE_XLAT   = 2'd0,
        MODE_TRANSP = 2'd1,
        MODE_PHASER = 2'd2
    } rx_mode_e;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_SSD2 = 2'd1,
        FR_DATA = 2'd2,
        FR_ESD2 = 2'd3
    } frame_st_e;

endpackage

// File: rtl/rx_mode_sel.sv
// Module: latches the bypass straps during reset and merges them with
// configuration bits into one operating mode; alignment bypass wins.
// Assumes straps are stable while rst_n is low.
module rx_mode_sel
    import rx4b5b_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     strap_code,
    input  logic     strap_align,
    input  logic     cfg_code,
    input  logic     cfg_align,
    output rx_mode_e mode
);
    logic strap_code_q;
    logic strap_align_q;

    // Capture strap levels only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_code_q  <= strap_code;
            strap_align_q <= strap_align;
        end
    end

    // Resolve the operating mode with alignment bypass first.
    always_comb begin
        if (strap_align_q || cfg_align)
            mode = MODE_PHASER;
        else if (strap_code_q || cfg_code)
            mode = MODE_TRANSP;
        else
            mode = MODE_XLAT;
    end
endmodule

// File: rtl/rx_cg_decode.sv
// Module: combinational 5B data code-group to nibble decoder.
// Flags whether the code-group is one of the sixteen data symbols.
module rx_cg_decode
    import rx4b5b_pkg::*;
(
    input  logic [CG_W-1:0]  cg,
    output logic [NIB_W-1:0] nib,
    output logic             is_data
);
    // Map each data code-group to its nibble.
    always_comb begin
        is_data = 1'b1;
        case (cg)
            5'b11110: nib = 4'h0;
            5'b01001: nib = 4'h1;
            5'b10100: nib = 4'h2;
            5'b10101: nib = 4'h3;
            5'b01010: nib = 4'h4;
            5'b01011: nib = 4'h5;
            5'b01110: nib = 4'h6;
            5'b01111: nib = 4'h7;
            5'b10010: nib = 4'h8;
            5'b10011: nib = 4'h9;
            5'b10110: nib = 4'hA;
            5'b10111: nib = 4'hB;
            5'b11010: nib = 4'hC;
            5'b11011: nib = 4'hD;
            5'b11100: nib = 4'hE;
            5'b11101: nib = 4'hF;
            default: begin
                nib     = '0;
                is_data = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/rx_frame_fsm.sv
// Module: stream framing state machine. Looks at the current code-group and
// the one behind it to find J/K and T/R pairs. Drives the next data-valid
// value, a preamble marker and an invalid-symbol marker.
// Assumes one code-group per clock; held idle in alignment bypass.
module rx_frame_fsm
    import rx4b5b_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  rx_mode_e        mode,
    input  logic [CG_W-1:0] cur_cg,
    input  logic [CG_W-1:0] nxt_cg,
    input  logic            cur_is_data,
    output logic            dv_nxt,
    output logic            pre_nxt,
    output logic            bad_nxt
);
    frame_st_e st_q, st_d;

    // Next-state and per-position framing decision.
    always_comb begin
        st_d    = st_q;
        dv_nxt  = 1'b0;
        pre_nxt = 1'b0;
        bad_nxt = 1'b0;
        if (mode == MODE_PHASER) begin
            st_d = FR_IDLE;
        end else begin
            case (st_q)
                FR_IDLE: begin
                    if (cur_cg == CG_J && nxt_cg == CG_K) begin
                        dv_nxt  = 1'b1;
                        pre_nxt = 1'b1;
                        st_d    = FR_SSD2;
                    end
                end
                FR_SSD2: begin
                    dv_nxt  = 1'b1;
                    pre_nxt = 1'b1;
                    st_d    = FR_DATA;
                end
                FR_DATA: begin
                    if (cur_cg == CG_T && nxt_cg == CG_R) begin
                        st_d = FR_ESD2;
                    end else if (cur_cg == CG_IDLE) begin
                        st_d = FR_IDLE;
                    end else begin
                        dv_nxt  = 1'b1;
                        bad_nxt = !cur_is_data;
                    end
                end
                default: st_d = FR_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FR_IDLE;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rx_4b5b_xlat.sv
// Module: top of the receive code-group translator. Stage one registers the
// code-group; stage two chooses decoded, bypassed or raw output by mode.
// Assumes one code-group per clock and a synchronous active-low reset.
module rx_4b5b_xlat
    import rx4b5b_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_bypass_code,
    input  logic             strap_bypass_align,
    input  logic             cfg_bypass_code,
    input  logic             cfg_bypass_align,
    input  logic [CG_W-1:0]  cg_in,
    output logic [NIB_W-1:0] rxd,
    output logic             rx_dv,
    output logic             rx_er
);
    rx_mode_e         mode_eff;
    logic [CG_W-1:0]  cg_s1;
    logic [NIB_W-1:0] dec_nib;
    logic             dec_ok;
    logic             fr_dv, fr_pre, fr_bad;
    logic [NIB_W-1:0] rxd_d;
    logic             dv_d, er_d;

    rx_mode_sel mode_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_code  (strap_bypass_code),
        .strap_align (strap_bypass_align),
        .cfg_code    (cfg_bypass_code),
        .cfg_align   (cfg_bypass_align),
        .mode        (mode_eff)
    );

    rx_cg_decode dec_i (
        .cg      (cg_s1),
        .nib     (dec_nib),
        .is_data (dec_ok)
    );

    rx_frame_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode_eff),
        .cur_cg      (cg_s1),
        .nxt_cg      (cg_in),
        .cur_is_data (dec_ok),
        .dv_nxt      (fr_dv),
        .pre_nxt     (fr_pre),
        .bad_nxt     (fr_bad)
    );

    // Stage one: hold the code-group so the next one acts as lookahead.
    always_ff @(posedge clk) begin
        if (!rst_n) cg_s1 <= CG_IDLE;
        else        cg_s1 <= cg_in;
    end

    // Select the stage-two output according to the active mode.
    always_comb begin
        case (mode_eff)
            MODE_TRANSP: begin
                dv_d  = fr_dv;
                rxd_d = (cg_s1 == CG_IDLE) ? '0 : cg_s1[NIB_W-1:0];
                er_d  = (cg_s1 == CG_IDLE) ? 1'b0 : cg_s1[CG_W-1];
            end
            MODE_PHASER: begin
                dv_d  = 1'b0;
                rxd_d = cg_s1[NIB_W-1:0];
                er_d  = cg_s1[CG_W-1];
            end
            default: begin
                dv_d  = fr_dv;
                er_d  = fr_bad;
                if (fr_pre)
                    rxd_d = NIB_PRE;
                else if (fr_dv && dec_ok)
                    rxd_d = dec_nib;
                else
                    rxd_d = '0;
            end
        endcase
    end

    // Stage two: output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxd   <= '0;
            rx_dv <= 1'b0;
            rx_er <= 1'b0;
        end else begin
            rxd   <= rxd_d;
            rx_dv <= dv_d;
            rx_er <= er_d;
        end
    end
endmodule

// File: rtl/rx_4b5b_xlat_chk.sv
// Module: property checker for the receive translator, bound to the top.
// Uses a warm-up counter so that no property looks back past reset.
module rx_4b5b_xlat_chk
    import rx4b5b_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CG_W-1:0]  cg_in,
    input rx_mode_e         mode,
    input logic [NIB_W-1:0] rxd,
    input logic             rx_dv,
    input logic             rx_er
);
    logic [1:0] warm_q;

    // Count clock edges since reset, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)             warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    // R8
    phaser_dv_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && $past(mode) == MODE_PHASER) |-> !rx_dv);

    // R6 R8 R10
    bypass_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && $past(mode) != MODE_XLAT && $past(mode, 2) == $past(mode)
         && $past(cg_in, 2) != CG_IDLE)
        |-> (rx_er == $past(cg_in[CG_W-1], 2) && rxd == $past(cg_in[NIB_W-1:0], 2)));

    // R2
    preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && $rose(rx_dv) && $past(mode) == MODE_XLAT) |-> rxd == NIB_PRE);

    // R4
    err_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && $past(mode) == MODE_XLAT && rx_er) |-> (rx_dv && rxd == '0));
endmodule

bind rx_4b5b_xlat rx_4b5b_xlat_chk chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cg_in (cg_in),
    .mode  (mode_eff),
    .rxd   (rxd),
    .rx_dv (rx_dv),
    .rx_er (rx_er)
);

// File: tb/rx_4b5b_xlat_tb_top.sv
module rx_4b5b_xlat_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_bypass_code = 1'b0;
    logic       strap_bypass_align = 1'b0;
    logic       cfg_bypass_code = 1'b0;
    logic       cfg_bypass_align = 1'b0;
    logic [4:0] cg_in = 5'h1F;
    logic [3:0] rxd;
    logic       rx_dv;
    logic       rx_er;

    int checks = 0;
    int fails  = 0;
    int cur_mode = 0;   // 0 translating, 1 code bypass, 2 alignment bypass
    int n = 0;

    logic [4:0] st_cg [0:127];
    logic [3:0] ex_d  [0:127];
    logic       ex_dv [0:127];
    logic       ex_er [0:127];

    localparam logic [4:0] J = 5'b11000, K = 5'b10001, T = 5'b01101, R = 5'b00111;

    always #10 clk = ~clk;   // 50 MHz

    rx_4b5b_xlat dut_i (
        .clk(clk), .rst_n(rst_n),
        .strap_bypass_code(strap_bypass_code), .strap_bypass_align(strap_bypass_align),
        .cfg_bypass_code(cfg_bypass_code), .cfg_bypass_align(cfg_bypass_align),
        .cg_in(cg_in), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er)
    );

    function automatic logic [4:0] enc(input int v);
        case (v)
            0: return 5'b11110;  1: return 5'b01001;  2: return 5'b10100;  3: return 5'b10101;
            4: return 5'b01010;  5: return 5'b01011;  6: return 5'b01110;  7: return 5'b01111;
            8: return 5'b10010;  9: return 5'b10011; 10: return 5'b10110; 11: return 5'b10111;
            12: return 5'b11010; 13: return 5'b11011; 14: return 5'b11100; default: return 5'b11101;
        endcase
    endfunction

    // Expected outputs: translating fields given, bypass modes derived per R6-R8.
    task automatic add(input logic [4:0] cg, input logic [3:0] xn, input logic xdv, input logic xer);
        st_cg[n] = cg;
        if (cur_mode == 0) begin
            ex_d[n] = xn; ex_dv[n] = xdv; ex_er[n] = xer;
        end else if (cur_mode == 1) begin
            ex_d[n]  = (cg == 5'h1F) ? 4'h0 : cg[3:0];
            ex_er[n] = (cg == 5'h1F) ? 1'b0 : cg[4];
            ex_dv[n] = xdv;
        end else begin
            ex_d[n] = cg[3:0]; ex_er[n] = cg[4]; ex_dv[n] = 1'b0;
        end
        n++;
    endtask

    task automatic add_idle(input int k);
        for (int i = 0; i < k; i++) add(5'h1F, 4'h0, 1'b0, 1'b0);
    endtask

    // Full frame carrying every data code-group (R1 R2 R3).
    task automatic build_a();
        n = 0;
        add_idle(3);
        add(J, 4'h5, 1'b1, 1'b0);
        add(K, 4'h5, 1'b1, 1'b0);
        for (int i = 0; i < 16; i++) add(enc(i), 4'(i), 1'b1, 1'b0);
        add(T, 4'h0, 1'b0, 1'b0);
        add(R, 4'h0, 1'b0, 1'b0);
        add_idle(3);
    endtask

    // Broken sequences: invalid in frame (R4), stray codes outside frame,
    // lone J (R2), idle ending a frame (R5).
    task automatic build_b();
        n = 0;
        add_idle(2);
        add(J, 4'h5, 1'b1, 1'b0);
        add(K, 4'h5, 1'b1, 1'b0);
        add(enc(3), 4'h3, 1'b1, 1'b0);
        add(5'b00000, 4'h0, 1'b1, 1'b1);
        add(enc(7), 4'h7, 1'b1, 1'b0);
        add(T, 4'h0, 1'b0, 1'b0);
        add(R, 4'h0, 1'b0, 1'b0);
        add_idle(2);
        add(5'b00100, 4'h0, 1'b0, 1'b0);
        add(J, 4'h0, 1'b0, 1'b0);
        add_idle(1);
        add(J, 4'h5, 1'b1, 1'b0);
        add(K, 4'h5, 1'b1, 1'b0);
        add(enc(10), 4'hA, 1'b1, 1'b0);
        add(5'h1F, 4'h0, 1'b0, 1'b0);
        add(enc(5), 4'h0, 1'b0, 1'b0);
        add(K, 4'h0, 1'b0, 1'b0);
        add_idle(2);
    endtask

    // Every raw code-group value (R8).
    task automatic build_c();
        n = 0;
        for (int i = 0; i < 32; i++) add(5'(i), 4'h0, 1'b0, 1'b0);
        add_idle(2);
    endtask

    // Drive at negedges; output for entry k-2 is visible at negedge k (R10).
    task automatic run(input string tag);
        for (int k = 0; k < n + 2; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                checks++;
                if (rxd !== ex_d[k-2] || rx_dv !== ex_dv[k-2] || rx_er !== ex_er[k-2]) begin
                    fails++;
                    $display("FAIL %s mode %0d idx %0d: got rxd=%h dv=%b er=%b exp rxd=%h dv=%b er=%b",
                             tag, cur_mode, k-2, rxd, rx_dv, rx_er, ex_d[k-2], ex_dv[k-2], ex_er[k-2]);
                end
            end
            cg_in = (k < n) ? st_cg[k] : 5'h1F;
        end
    endtask

    // Reset with given straps; check outputs are zero in reset (R10), then drop straps (R9).
    task automatic do_reset(input logic sc, input logic sa);
        @(negedge clk);
        rst_n = 1'b0; cg_in = 5'h1F;
        strap_bypass_code = sc; strap_bypass_align = sa;
        repeat (3) @(negedge clk);
        checks++;
        if (rxd !== 4'h0 || rx_dv !== 1'b0 || rx_er !== 1'b0) begin
            fails++;
            $display("FAIL R10 reset: got rxd=%h dv=%b er=%b exp rxd=0 dv=0 er=0", rxd, rx_dv, rx_er);
        end
        rst_n = 1'b1;
        strap_bypass_code = 1'b0; strap_bypass_align = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: got hang exp completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // Translating mode
        do_reset(1'b0, 1'b0);
        cur_mode = 0; build_a(); run("R1_R2_R3");
        build_b(); run("R2_R4_R5");
        // Code bypass via configuration
        cfg_bypass_code = 1'b1; cur_mode = 1;
        do_reset(1'b0, 1'b0);
        build_a(); run("R6_R7");
        build_b(); run("R6_R7");
        // Alignment bypass via configuration
        cfg_bypass_code = 1'b0; cfg_bypass_align = 1'b1; cur_mode = 2;
        do_reset(1'b0, 1'b0);
        build_a(); run("R8");
        build_c(); run("R8");
        // Both requested: alignment wins
        cfg_bypass_code = 1'b1;
        do_reset(1'b0, 1'b0);
        build_b(); run("R9");
        // Straps only
        cfg_bypass_code = 1'b0; cfg_bypass_align = 1'b0;
        do_reset(1'b0, 1'b1); cur_mode = 2;
        build_a(); run("R9");
        do_reset(1'b1, 1'b0); cur_mode = 1;
        build_b(); run("R9");
        do_reset(1'b1, 1'b1); cur_mode = 2;
        build_b(); run("R9");
        do_reset(1'b0, 1'b0); cur_mode = 0;
        build_b(); run("R9_R10");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule